// File: doc/BRIEF.md
# SPI NOR Flash Command and Address Front-End

This block sits in a serial flash slave, directly behind the byte deserializer. It watches the byte stream of a transaction framed by an active-low chip select. The first byte is taken as the opcode. For addressed commands the block works out the address length and the dummy-byte count. It then assembles the address and emits a one-cycle go strobe with an operation code and the final byte address. The storage array, the serial shifter and the configuration registers live elsewhere. The block only reads the write-enable state, a two-byte (EEPROM-style) strap and the dummy-count field of the volatile configuration.

The block holds two pieces of state of its own: the wide (4-byte) address mode flag and an 8-bit extended segment register. With a 3-byte address, the low two bits of that register select a 16 MiB segment. Two read-back opcodes return a one-byte response: the segment register, and a flag-status byte. An unknown opcode raises an error pulse. The rest of that transaction is then ignored.

Top module: `nor_cmd_front`

## Requirements
- R1: The 3-byte-form opcodes are read 0x03, program 0x02, 4 KiB erase 0x20 and sector erase 0xD8. Outside wide mode each collects three address bytes, most significant first. One cycle after the byte that completes the command, op_go pulses high for one cycle with op_addr and op_kind. The op_kind codes are: 0 read, 1 fast read, 2 dual-output read, 3 quad-output read, 4 page program, 5 4 KiB erase, 6 sector erase.
- R2: The 4-byte-form opcodes 0x13 (read), 0x0C (fast read), 0x3C (dual), 0x6C (quad), 0x12 (program), 0x21 (4 KiB erase) and 0xDC (sector erase) always collect four address bytes. No segment offset is added to their address.
- R3: Opcode 0xB7 sets wide mode and 0xE9 clears it. While wide mode is set, the 3-byte-form opcodes collect four address bytes.
- R4: While eeprom_cfg is high, every addressed opcode collects exactly two address bytes, and the address is those 16 bits.
- R5: When three address bytes are collected, op_addr equals the assembled address plus the segment register's low two bits times 0x1000000.
- R6: Opcode 0xC8 pulses rsp_valid one cycle later with rsp_byte equal to the segment register. Opcode 0xC5 loads the next byte into that register only if wr_en is high at the opcode. Otherwise the command and its data byte leave the register unchanged.
- R7: Fast read (0x0B/0x0C), dual-output read (0x3B/0x3C) and quad-output read (0x6B/0x6C) collect the address bytes plus dummy_cfg further bytes. op_go follows the last of these bytes. Dummy byte values do not affect op_addr.
- R8: Opcode 0x70 pulses rsp_valid one cycle later. Bit 7 of rsp_byte is 1, bit 0 is the wide mode flag, and the other bits are 0.
- R9: Raising cs_n before a command has collected all its bytes abandons it. No op_go is issued, and the next transaction starts with a fresh opcode.
- R10: Any other opcode pulses cmd_err for one cycle. All further bytes are ignored until cs_n rises.
- R11: After reset all pulses are low, wide mode is clear and the segment register is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Active-low chip select framing a transaction |
| rx_valid | input | 1 | A received byte is present this cycle |
| rx_byte | input | 8 | Received byte |
| wr_en | input | 1 | Write-enable state from the status logic |
| eeprom_cfg | input | 1 | Strap: two address bytes for every command |
| dummy_cfg | input | DUMMY_W | Dummy-byte count from the volatile configuration |
| op_go | output | 1 | One-cycle strobe: operation ready |
| op_kind | output | 3 | Operation code, valid with op_go |
| op_addr | output | 32 | Final byte address, valid with op_go |
| rsp_valid | output | 1 | One-cycle strobe: response byte ready |
| rsp_byte | output | 8 | Response byte for the read-back opcodes |
| cmd_err | output | 1 | One-cycle strobe: unknown opcode |

## Verification
The same address bytes are sent with a plain opcode in normal mode, with its 4-byte form, in wide mode and under the two-byte strap. Checking when op_go appears shows whether the length is chosen per command, per mode or per strap. The segment register is loaded with different values, including one with high bits set. This separates the 3-byte path, which adds the offset and uses only two bits, from the 4-byte and two-byte paths, which ignore it. Reads are sent with zero and non-zero dummy counts, and some commands are broken off by chip select or follow a bad opcode. These show that the go strobe waits for the dummy bytes and never comes from an abandoned or rejected command.

// File: rtl/nor_cmd_front.sv
module nor_cmd_front #(
  parameter int DUMMY_W = 4,
  parameter int SEG_W   = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cs_n,
  input  logic               rx_valid,
  input  logic [7:0]         rx_byte,
  input  logic               wr_en,
  input  logic               eeprom_cfg,
  input  logic [DUMMY_W-1:0] dummy_cfg,
  output logic               op_go,
  output logic [2:0]         op_kind,
  output logic [31:0]        op_addr,
  output logic               rsp_valid,
  output logic [7:0]         rsp_byte,
  output logic               cmd_err
);
  localparam int CNT_W = $clog2(4 + (1 << DUMMY_W));
  localparam logic [2:0] K_RD = 3'd0, K_FRD = 3'd1, K_DRD = 3'd2, K_QRD = 3'd3,
                         K_PGM = 3'd4, K_E4K = 3'd5, K_ESC = 3'd6;

  typedef enum logic [1:0] {S_IDLE, S_COLLECT, S_HOLD} st_t;
  st_t st;

  logic             wide, to_seg;
  logic [7:0]       seg;
  logic [2:0]       kind;
  logic [CNT_W-1:0] alen, need, cnt;
  logic [31:0]      sh;

  logic             is_addr, has_dummy, force4;
  logic [2:0]       kind_d;
  logic [CNT_W-1:0] alen_d, need_d;
  logic [31:0]      sh_n, fin;

  always_comb begin
    is_addr = 1'b1; has_dummy = 1'b0; force4 = 1'b0; kind_d = K_RD;
    case (rx_byte)
      8'h03: kind_d = K_RD;
      8'h13: begin kind_d = K_RD;  force4 = 1'b1; end
      8'h0B: begin kind_d = K_FRD; has_dummy = 1'b1; end
      8'h0C: begin kind_d = K_FRD; has_dummy = 1'b1; force4 = 1'b1; end
      8'h3B: begin kind_d = K_DRD; has_dummy = 1'b1; end
      8'h3C: begin kind_d = K_DRD; has_dummy = 1'b1; force4 = 1'b1; end
      8'h6B: begin kind_d = K_QRD; has_dummy = 1'b1; end
      8'h6C: begin kind_d = K_QRD; has_dummy = 1'b1; force4 = 1'b1; end
      8'h02: kind_d = K_PGM;
      8'h12: begin kind_d = K_PGM; force4 = 1'b1; end
      8'h20: kind_d = K_E4K;
      8'h21: begin kind_d = K_E4K; force4 = 1'b1; end
      8'hD8: kind_d = K_ESC;
      8'hDC: begin kind_d = K_ESC; force4 = 1'b1; end
      default: is_addr = 1'b0;
    endcase
  end

  assign alen_d = eeprom_cfg ? CNT_W'(2) : (force4 || wide) ? CNT_W'(4) : CNT_W'(3);
  assign need_d = alen_d + (has_dummy ? CNT_W'(dummy_cfg) : CNT_W'(0));
  assign sh_n   = (cnt < alen) ? {sh[23:0], rx_byte} : sh;
  assign fin    = (alen == CNT_W'(3))
                ? sh_n + ({{(32-SEG_W){1'b0}}, seg[SEG_W-1:0]} << 24)
                : sh_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; wide <= 1'b0; seg <= 8'h00; to_seg <= 1'b0;
      kind <= K_RD; alen <= '0; need <= '0; cnt <= '0; sh <= '0;
      op_go <= 1'b0; op_kind <= K_RD; op_addr <= '0;
      rsp_valid <= 1'b0; rsp_byte <= 8'h00; cmd_err <= 1'b0;
    end else begin
      op_go <= 1'b0; rsp_valid <= 1'b0; cmd_err <= 1'b0;
      if (cs_n) begin
        st <= S_IDLE;
      end else if (rx_valid) begin
        case (st)
          S_IDLE: begin
            st <= S_HOLD; cnt <= '0; sh <= '0; to_seg <= 1'b0;
            if (is_addr) begin
              st <= S_COLLECT; kind <= kind_d; alen <= alen_d; need <= need_d;
            end else begin
              case (rx_byte)
                8'hB7: wide <= 1'b1;
                8'hE9: wide <= 1'b0;
                8'hC8: begin rsp_valid <= 1'b1; rsp_byte <= seg; end
                8'h70: begin rsp_valid <= 1'b1; rsp_byte <= {7'b1000000, wide}; end
                8'hC5: if (wr_en) begin
                  st <= S_COLLECT; to_seg <= 1'b1; alen <= '0; need <= CNT_W'(1);
                end
                default: cmd_err <= 1'b1;
              endcase
            end
          end
          S_COLLECT: begin
            cnt <= cnt + CNT_W'(1);
            sh  <= sh_n;
            if (cnt == need - CNT_W'(1)) begin
              st <= S_HOLD;
              if (to_seg) seg <= rx_byte;
              else begin
                op_go <= 1'b1; op_kind <= kind; op_addr <= fin;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/nor_cmd_front_chk.sv
module nor_cmd_front_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_n,
  input logic       rx_valid,
  input logic       op_go,
  input logic       rsp_valid,
  input logic [7:0] rsp_byte,
  input logic       cmd_err
);
  // R1
  go_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_go |=> !op_go);
  // R9
  cs_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> !(op_go || rsp_valid || cmd_err));
  // R1
  byte_driven_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid |=> !(op_go || rsp_valid || cmd_err));
  // R10
  err_alone_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_err |-> !(op_go || rsp_valid));
  // R10
  err_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_err |=> !cmd_err);
  // R6
  rsp_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !op_go);
endmodule

bind nor_cmd_front nor_cmd_front_chk chk_i (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rx_valid(rx_valid),
  .op_go(op_go), .rsp_valid(rsp_valid), .rsp_byte(rsp_byte), .cmd_err(cmd_err)
);

// File: tb/nor_cmd_front_tb.sv
module nor_cmd_front_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, rx_valid = 1'b0;
  logic [7:0] rx_byte = 8'h00;
  logic wr_en = 1'b0, eeprom_cfg = 1'b0;
  logic [3:0] dummy_cfg = 4'd0;
  logic op_go, rsp_valid, cmd_err;
  logic [2:0] op_kind;
  logic [31:0] op_addr;
  logic [7:0] rsp_byte;

  int n_chk = 0, n_bad = 0, go_cnt = 0;
  logic g_go, g_rsp, g_err;
  logic [2:0] g_kind;
  logic [31:0] g_addr;
  logic [7:0] g_rb;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nor_cmd_front dut_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .wr_en(wr_en), .eeprom_cfg(eeprom_cfg), .dummy_cfg(dummy_cfg),
    .op_go(op_go), .op_kind(op_kind), .op_addr(op_addr),
    .rsp_valid(rsp_valid), .rsp_byte(rsp_byte), .cmd_err(cmd_err)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk); rx_valid = 1'b1; rx_byte = b;
    @(negedge clk); rx_valid = 1'b0;
    g_go = op_go; g_kind = op_kind; g_addr = op_addr;
    g_rsp = rsp_valid; g_rb = rsp_byte; g_err = cmd_err;
    if (op_go) go_cnt++;
  endtask

  task automatic cs_lo; @(negedge clk); cs_n = 1'b0; endtask
  task automatic cs_hi; @(negedge clk); cs_n = 1'b1; @(negedge clk); endtask

  task automatic one_byte(input logic [7:0] b);
    cs_lo(); send(b); cs_hi();
  endtask

  task automatic addr_cmd(input logic [7:0] op, input int n, input logic [31:0] a,
                          input int dummies);
    cs_lo(); send(op);
    for (int i = n - 1; i >= 0; i--) send(a[8*i +: 8]);
    for (int i = 0; i < dummies; i++) send(8'h5A);
    cs_hi();
  endtask

  task automatic set_seg(input logic [7:0] v);
    wr_en = 1'b1; cs_lo(); send(8'hC5); send(v); cs_hi(); wr_en = 1'b0;
  endtask

  task automatic read_seg(input logic [7:0] exp);
    cs_lo(); send(8'hC8);
    chk("R6 rsp_valid on 0xC8", 32'(g_rsp), 32'd1);
    chk("R6 segment readback", 32'(g_rb), 32'(exp));
    cs_hi();
  endtask

  task automatic read_fsr(input logic [7:0] exp);
    cs_lo(); send(8'h70);
    chk("R8 rsp_valid on 0x70", 32'(g_rsp), 32'd1);
    chk("R8 flag status", 32'(g_rb), 32'(exp));
    cs_hi();
  endtask

  task automatic t_reset;
    chk("R11 op_go after reset", 32'(op_go), 32'd0);
    chk("R11 rsp_valid after reset", 32'(rsp_valid), 32'd0);
    chk("R11 cmd_err after reset", 32'(cmd_err), 32'd0);
    read_fsr(8'h80);
    read_seg(8'h00);
  endtask

  task automatic t_plain;
    int g0;
    g0 = go_cnt;
    addr_cmd(8'h03, 3, 32'h00123456, 0);
    chk("R1 read go count", 32'(go_cnt - g0), 32'd1);
    chk("R1 read addr", g_addr, 32'h00123456);
    chk("R1 read kind", 32'(g_kind), 32'd0);
    addr_cmd(8'h02, 3, 32'h00ABCDEF, 0);
    chk("R1 program kind", 32'(g_kind), 32'd4);
    chk("R1 program addr", g_addr, 32'h00ABCDEF);
    addr_cmd(8'h20, 3, 32'h00001000, 0);
    chk("R1 erase4k kind", 32'(g_kind), 32'd5);
    addr_cmd(8'hD8, 3, 32'h00010000, 0);
    chk("R1 sector erase kind", 32'(g_kind), 32'd6);
    chk("R1 sector erase addr", g_addr, 32'h00010000);
  endtask

  task automatic t_segment;
    wr_en = 1'b0; cs_lo(); send(8'hC5); send(8'h03); cs_hi();
    read_seg(8'h00);
    set_seg(8'h02);
    read_seg(8'h02);
    addr_cmd(8'h03, 3, 32'h00ABCDEF, 0);
    chk("R5 segment 2 addr", g_addr, 32'h02ABCDEF);
    set_seg(8'h07);
    read_seg(8'h07);
    addr_cmd(8'h02, 3, 32'h00ABCDEF, 0);
    chk("R5 segment low bits only", g_addr, 32'h03ABCDEF);
  endtask

  task automatic t_four;
    int g0;
    addr_cmd(8'h13, 4, 32'h89ABCDEF, 0);
    chk("R2 0x13 addr no segment", g_addr, 32'h89ABCDEF);
    chk("R2 0x13 kind", 32'(g_kind), 32'd0);
    addr_cmd(8'hDC, 4, 32'h01000000, 0);
    chk("R2 0xDC kind", 32'(g_kind), 32'd6);
    chk("R2 0xDC addr", g_addr, 32'h01000000);
    addr_cmd(8'h21, 4, 32'h00002000, 0);
    chk("R2 0x21 kind", 32'(g_kind), 32'd5);
    addr_cmd(8'h12, 4, 32'h7F000001, 0);
    chk("R2 0x12 kind", 32'(g_kind), 32'd4);
    chk("R2 0x12 addr", g_addr, 32'h7F000001);
    g0 = go_cnt;
    cs_lo(); send(8'h13); send(8'h11); send(8'h22); send(8'h33);
    chk("R2 no go after three bytes", 32'(go_cnt - g0), 32'd0);
    cs_hi();
  endtask

  task automatic t_wide;
    int g0;
    one_byte(8'hB7);
    read_fsr(8'h81);
    g0 = go_cnt;
    cs_lo(); send(8'h03); send(8'h01); send(8'h02); send(8'h03);
    chk("R3 wide: no go after three bytes", 32'(go_cnt - g0), 32'd0);
    send(8'h04);
    chk("R3 wide: go after four bytes", 32'(go_cnt - g0), 32'd1);
    chk("R3 wide addr no segment", g_addr, 32'h01020304);
    cs_hi();
    one_byte(8'hE9);
    read_fsr(8'h80);
    addr_cmd(8'h03, 3, 32'h00010203, 0);
    chk("R3 back to 3 bytes with segment", g_addr, 32'h03010203);
  endtask

  task automatic t_eeprom;
    int g0;
    eeprom_cfg = 1'b1;
    g0 = go_cnt;
    addr_cmd(8'h13, 2, 32'h00001234, 0);
    chk("R4 two-byte go", 32'(go_cnt - g0), 32'd1);
    chk("R4 two-byte addr", g_addr, 32'h00001234);
    one_byte(8'hB7);
    addr_cmd(8'h02, 2, 32'h0000BEEF, 0);
    chk("R4 two-byte in wide mode", g_addr, 32'h0000BEEF);
    one_byte(8'hE9);
    eeprom_cfg = 1'b0;
  endtask

  task automatic t_dummy;
    int g0;
    set_seg(8'h00);
    dummy_cfg = 4'd2;
    g0 = go_cnt;
    cs_lo(); send(8'h0B); send(8'h01); send(8'h02); send(8'h03);
    chk("R7 no go at address end", 32'(go_cnt - g0), 32'd0);
    send(8'hFF);
    chk("R7 no go after first dummy", 32'(go_cnt - g0), 32'd0);
    send(8'hEE);
    chk("R7 go after dummies", 32'(go_cnt - g0), 32'd1);
    chk("R7 fast read addr", g_addr, 32'h00010203);
    chk("R7 fast read kind", 32'(g_kind), 32'd1);
    cs_hi();
    dummy_cfg = 4'd1;
    addr_cmd(8'h6C, 4, 32'hA1B2C3D4, 1);
    chk("R7 quad 4-byte addr", g_addr, 32'hA1B2C3D4);
    chk("R7 quad kind", 32'(g_kind), 32'd3);
    dummy_cfg = 4'd0;
    g0 = go_cnt;
    addr_cmd(8'h3B, 3, 32'h00456789, 0);
    chk("R7 dual with zero dummies", 32'(go_cnt - g0), 32'd1);
    chk("R7 dual kind", 32'(g_kind), 32'd2);
    chk("R7 dual addr", g_addr, 32'h00456789);
  endtask

  task automatic t_abandon;
    int g0;
    g0 = go_cnt;
    cs_lo(); send(8'h02); send(8'h12); send(8'h34); cs_hi();
    chk("R9 abandoned: no go", 32'(go_cnt - g0), 32'd0);
    read_fsr(8'h80);
    set_seg(8'h01);
    cs_lo(); send(8'hC5); cs_hi();
    read_seg(8'h01);
    addr_cmd(8'h03, 3, 32'h00000010, 0);
    chk("R9 fresh command after abandon", g_addr, 32'h01000010);
  endtask

  task automatic t_error;
    int g0;
    g0 = go_cnt;
    cs_lo(); send(8'h5A);
    chk("R10 cmd_err pulse", 32'(g_err), 32'd1);
    send(8'h03);
    chk("R10 cmd_err one cycle", 32'(g_err), 32'd0);
    send(8'h11); send(8'h22); send(8'h33); send(8'hB7);
    chk("R10 ignored bytes: no go", 32'(go_cnt - g0), 32'd0);
    cs_hi();
    read_fsr(8'h80);
    addr_cmd(8'h03, 3, 32'h00000020, 0);
    chk("R10 recovery after cs", g_addr, 32'h01000020);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_plain();
    t_segment();
    t_four();
    t_wide();
    t_eeprom();
    t_dummy();
    t_abandon();
    t_error();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule